// File: doc/BRIEF.md
# Nested Speculation Checkpoint Controller

This block lets an in-order integer pipeline keep executing down a predicted path while up to a parameterised number (default four) of branch or floating-point events remain unresolved. Each time such an event issues, the controller saves a snapshot of a small architectural state: a packed register file, a flags word and an environment word. It then raises its speculation level by one. Resolutions come back oldest first. A correct prediction releases the oldest snapshot and keeps the live state. A misprediction drives the oldest snapshot back out on the restore port one cycle later, together with the corrected fetch address, and clears all speculation.

Stores pass through a small in-order buffer. Each entry carries a relative dependency tag: the number of older unresolved events at the moment the store was accepted. Every correct resolution lowers all non-zero tags by one. A store drains to memory only from the head of the buffer and only when its tag is zero. A misprediction removes every store that still has a non-zero tag.

The block also raises a halt (stall) request in four cases: when speculation cannot go deeper, on a fault, on a write to state that has no snapshot, and when the store buffer is full.

Top module: `spec_ckpt_ctrl`

## Requirements
- R1: After synchronous reset the level is 0, restore_valid and cm_valid are 0, st_ready is 1 and stall is 0 while all inputs are low.
- R2: A ckpt_req at level below DEPTH, in a cycle with no misprediction, saves {ckpt_regs, ckpt_flags, ckpt_env} and raises the level by one at the next edge. A correct resolution in the same cycle lowers it by one, so the level is then unchanged.
- R3: The level never exceeds DEPTH. A ckpt_req at level DEPTH is dropped and drives stall high in that cycle.
- R4: A res_valid with res_mispred=0 at a non-zero level lowers the level by one, discards the oldest snapshot and produces no restore pulse.
- R5: A res_valid with res_mispred=1 at a non-zero level produces, on the next cycle only, restore_valid=1 with the oldest live snapshot on the restore outputs and res_target on redirect_addr. It also sets the level to 0. A ckpt_req or a store offered in the same cycle is dropped.
- R6: A res_valid at level 0 has no effect on the level and produces no restore pulse.
- R7: A store accepted in a cycle gets tag = level minus one if a correct resolution arrives in that cycle, and tag = level otherwise. Stores leave through cm_valid/cm_addr/cm_data strictly in acceptance order. The head store is offered only while its tag is 0, and cm_valid stays high with a stable address until cm_ready.
- R8: A misprediction keeps the buffered stores whose tag is 0 and removes all others.
- R9: stall is high in any cycle where fault or nonckpt_wr is high.
- R10: When the store buffer holds SB entries, st_ready is 0 and stall is 1, and a store offered then is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ckpt_req | input | 1 | Branch or floating-point event issued on the predicted path |
| ckpt_regs | input | NREG*XLEN | Register file snapshot to save |
| ckpt_flags | input | FW | Flags word to save |
| ckpt_env | input | EW | Environment word to save |
| res_valid | input | 1 | Oldest event resolves this cycle |
| res_mispred | input | 1 | Resolution was a misprediction |
| res_target | input | AW | Corrected fetch address for a misprediction |
| fault | input | 1 | Exception or fault present |
| nonckpt_wr | input | 1 | Instruction writes state without a snapshot |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store buffer has room |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| cm_valid | output | 1 | Non-speculative store offered to memory |
| cm_ready | input | 1 | Memory accepts the offered store |
| cm_addr | output | AW | Committed store address |
| cm_data | output | DW | Committed store data |
| restore_valid | output | 1 | One-cycle restore strobe |
| restore_regs | output | NREG*XLEN | Restored register file |
| restore_flags | output | FW | Restored flags word |
| restore_env | output | EW | Restored environment word |
| redirect_addr | output | AW | Corrected fetch address |
| spec_level | output | $clog2(DEPTH+1) | Current number of unresolved events |
| stall | output | 1 | Speculation must halt |

## Verification
The assertions check the level bounds and steps on every cycle: the ceiling at DEPTH, the increment on a lone request, the decrement on a lone correct resolution and the inertness at level zero. They also check that a restore strobe lasts one cycle and leaves the level empty, and that an offered commit holds until taken. Only the bench scenarios can show that the restored words are exactly the oldest live snapshot, that tags age correctly across interleaved resolutions, and that a misprediction flushes exactly the tagged tail of the store buffer while the untagged prefix drains in order.

// File: rtl/spec_ckpt_pkg.sv
package spec_ckpt_pkg;
  localparam int DEF_DEPTH = 4;
  localparam int DEF_NREG  = 4;
  localparam int DEF_XLEN  = 16;
  localparam int DEF_FW    = 8;
  localparam int DEF_EW    = 8;
  localparam int DEF_AW    = 16;
  localparam int DEF_DW    = 16;
  localparam int DEF_SB    = 4;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2
  } res_kind_e;
endpackage

// File: rtl/spec_ckpt_stack.sv
module spec_ckpt_stack #(
  parameter int DEPTH = 4,
  parameter int SW    = 80,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          clear,
  input  logic [SW-1:0] din,
  output logic [LW-1:0] level,
  output logic [SW-1:0] oldest
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SW-1:0] snap_mem [DEPTH];
  logic [PW-1:0] hd_q, tl_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    int s;
    s = int'(p) + 1;
    if (s >= DEPTH) s = 0;
    return PW'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (push) snap_mem[tl_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hd_q  <= '0;
      tl_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (pop)  hd_q <= bump(hd_q);
      if (push) tl_q <= bump(tl_q);
      lvl_q <= lvl_q + LW'(push) - LW'(pop);
    end
  end

  assign level  = lvl_q;
  assign oldest = snap_mem[hd_q];
endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf #(
  parameter int SB = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 3,
  localparam int PW = (SB > 1) ? $clog2(SB) : 1,
  localparam int CW = $clog2(SB + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tag,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          age,
  input  logic          flush,
  input  logic          rd_en,
  output logic          full,
  output logic          head_valid,
  output logic          head_free,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);
  logic [AW-1:0] addr_mem [SB];
  logic [DW-1:0] data_mem [SB];
  logic [TW-1:0] tag_q    [SB];
  logic [PW-1:0] hd_q, tl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] keep_cnt;

  function automatic logic [PW-1:0] slot(input logic [PW-1:0] base, input int off);
    int s;
    s = int'(base) + off;
    if (s >= SB) s = s - SB;
    return PW'(s);
  endfunction

  // entries with a zero tag form a prefix from the head
  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < SB; i++) begin
      if (i < int'(cnt_q) && tag_q[slot(hd_q, i)] == '0)
        keep_cnt = keep_cnt + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_mem[tl_q] <= wr_addr;
      data_mem[tl_q] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hd_q  <= '0;
      tl_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < SB; i++) tag_q[i] <= '0;
    end else begin
      if (age) begin
        for (int i = 0; i < SB; i++)
          if (tag_q[i] != '0) tag_q[i] <= tag_q[i] - TW'(1);
      end
      if (wr_en) tag_q[tl_q] <= wr_tag;
      if (rd_en) hd_q <= slot(hd_q, 1);
      if (flush) begin
        tl_q  <= slot(hd_q, int'(keep_cnt));
        cnt_q <= keep_cnt - CW'(rd_en);
      end else begin
        if (wr_en) tl_q <= slot(tl_q, 1);
        cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_en);
      end
    end
  end

  assign full       = (cnt_q == CW'(SB));
  assign head_valid = (cnt_q != '0);
  assign head_free  = (tag_q[hd_q] == '0);
  assign head_addr  = addr_mem[hd_q];
  assign head_data  = data_mem[hd_q];
endmodule

// File: rtl/spec_ckpt_ctrl.sv
module spec_ckpt_ctrl
  import spec_ckpt_pkg::*;
#(
  parameter int DEPTH = DEF_DEPTH,
  parameter int NREG  = DEF_NREG,
  parameter int XLEN  = DEF_XLEN,
  parameter int FW    = DEF_FW,
  parameter int EW    = DEF_EW,
  parameter int AW    = DEF_AW,
  parameter int DW    = DEF_DW,
  parameter int SB    = DEF_SB,
  localparam int RW   = NREG * XLEN,
  localparam int SW   = RW + FW + EW,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ckpt_req,
  input  logic [RW-1:0] ckpt_regs,
  input  logic [FW-1:0] ckpt_flags,
  input  logic [EW-1:0] ckpt_env,
  input  logic          res_valid,
  input  logic          res_mispred,
  input  logic [AW-1:0] res_target,
  input  logic          fault,
  input  logic          nonckpt_wr,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          cm_valid,
  input  logic          cm_ready,
  output logic [AW-1:0] cm_addr,
  output logic [DW-1:0] cm_data,
  output logic          restore_valid,
  output logic [RW-1:0] restore_regs,
  output logic [FW-1:0] restore_flags,
  output logic [EW-1:0] restore_env,
  output logic [AW-1:0] redirect_addr,
  output logic [LW-1:0] spec_level,
  output logic          stall
);
  res_kind_e     res_kind;
  logic          at_top;
  logic          do_push, do_pop, do_miss;
  logic          sb_full, sb_head_valid, sb_head_free, sb_wr, sb_rd;
  logic [SW-1:0] snap_out;
  logic [LW-1:0] st_tag;

  always_comb begin
    res_kind = RES_NONE;
    if (res_valid && spec_level != '0)
      res_kind = res_mispred ? RES_MISS : RES_HIT;
  end

  assign at_top  = (spec_level == LW'(DEPTH));
  assign do_miss = (res_kind == RES_MISS);
  assign do_pop  = (res_kind == RES_HIT);
  assign do_push = ckpt_req && !at_top && !do_miss;

  spec_ckpt_stack #(.DEPTH(DEPTH), .SW(SW), .LW(LW)) u_stack (
    .clk    (clk),
    .rst    (rst),
    .push   (do_push),
    .pop    (do_pop),
    .clear  (do_miss),
    .din    ({ckpt_regs, ckpt_flags, ckpt_env}),
    .level  (spec_level),
    .oldest (snap_out)
  );

  assign st_tag = spec_level - LW'(do_pop);
  assign sb_wr  = st_valid && !sb_full && !do_miss;
  assign sb_rd  = cm_valid && cm_ready;

  spec_store_buf #(.SB(SB), .AW(AW), .DW(DW), .TW(LW)) u_sbuf (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (sb_wr),
    .wr_tag     (st_tag),
    .wr_addr    (st_addr),
    .wr_data    (st_data),
    .age        (do_pop),
    .flush      (do_miss),
    .rd_en      (sb_rd),
    .full       (sb_full),
    .head_valid (sb_head_valid),
    .head_free  (sb_head_free),
    .head_addr  (cm_addr),
    .head_data  (cm_data)
  );

  assign cm_valid = sb_head_valid && sb_head_free;
  assign st_ready = !sb_full;
  assign stall    = (ckpt_req && at_top) || fault || nonckpt_wr || sb_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      restore_valid <= 1'b0;
      restore_regs  <= '0;
      restore_flags <= '0;
      restore_env   <= '0;
      redirect_addr <= '0;
    end else begin
      restore_valid <= do_miss;
      if (do_miss) begin
        {restore_regs, restore_flags, restore_env} <= snap_out;
        redirect_addr <= res_target;
      end
    end
  end
endmodule

// File: rtl/spec_ckpt_chk.sv
module spec_ckpt_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          ckpt_req,
  input logic          res_valid,
  input logic          res_mispred,
  input logic          fault,
  input logic          nonckpt_wr,
  input logic          st_ready,
  input logic          stall,
  input logic          cm_valid,
  input logic          cm_ready,
  input logic [AW-1:0] cm_addr,
  input logic          restore_valid,
  input logic [LW-1:0] spec_level
);
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    int'(spec_level) <= DEPTH); // R3
  AST_TOP_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ckpt_req && int'(spec_level) == DEPTH && !res_valid) |=> int'(spec_level) == DEPTH); // R3
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (ckpt_req && !res_valid && int'(spec_level) < DEPTH) |=> spec_level == $past(spec_level) + LW'(1)); // R2
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_mispred && !ckpt_req && spec_level != '0) |=> spec_level == $past(spec_level) - LW'(1)); // R4
  AST_RESTORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    restore_valid |=> !restore_valid); // R5
  AST_RESTORE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    restore_valid |-> spec_level == '0); // R5
  AST_IDLE_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    (res_valid && spec_level == '0 && !ckpt_req) |=> (spec_level == '0 && !restore_valid)); // R6
  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_addr))); // R7
  AST_HALT_STALL: assert property (@(posedge clk) disable iff (rst)
    (fault || nonckpt_wr) |-> stall); // R9
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    !st_ready |-> stall); // R10
endmodule

bind spec_ckpt_ctrl spec_ckpt_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ckpt_req      (ckpt_req),
  .res_valid     (res_valid),
  .res_mispred   (res_mispred),
  .fault         (fault),
  .nonckpt_wr    (nonckpt_wr),
  .st_ready      (st_ready),
  .stall         (stall),
  .cm_valid      (cm_valid),
  .cm_ready      (cm_ready),
  .cm_addr       (cm_addr),
  .restore_valid (restore_valid),
  .spec_level    (spec_level)
);

// File: tb/spec_ckpt_ctrl_test.sv
`timescale 1ns/1ps
module spec_ckpt_ctrl_test;
  localparam int DEP = 4;
  localparam int SBD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ckpt_req = 0, res_valid = 0, res_mispred = 0, fault = 0, nonckpt_wr = 0;
  logic        st_valid = 0, cm_ready = 0;
  logic [63:0] ckpt_regs = '0;
  logic [7:0]  ckpt_flags = '0, ckpt_env = '0;
  logic [15:0] res_target = '0, st_addr = '0, st_data = '0;
  logic        st_ready, cm_valid, restore_valid, stall;
  logic [15:0] cm_addr, cm_data, redirect_addr;
  logic [63:0] restore_regs;
  logic [7:0]  restore_flags, restore_env;
  logic [2:0]  spec_level;

  int checks = 0;
  int errors = 0;

  // reference model state
  int          lvl = 0;
  logic [63:0] mr[DEP];
  logic [7:0]  mf[DEP], me[DEP];
  int          sc = 0;
  logic [15:0] sa[SBD], sd[SBD];
  int          stg[SBD];
  bit          m_rv = 0;
  logic [63:0] m_rregs = '0;
  logic [7:0]  m_rflags = '0, m_renv = '0;
  logic [15:0] m_redir = '0;

  always #4 clk = ~clk;

  spec_ckpt_ctrl uut (
    .clk(clk), .rst(rst), .ckpt_req(ckpt_req), .ckpt_regs(ckpt_regs),
    .ckpt_flags(ckpt_flags), .ckpt_env(ckpt_env), .res_valid(res_valid),
    .res_mispred(res_mispred), .res_target(res_target), .fault(fault),
    .nonckpt_wr(nonckpt_wr), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .cm_valid(cm_valid),
    .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data),
    .restore_valid(restore_valid), .restore_regs(restore_regs),
    .restore_flags(restore_flags), .restore_env(restore_env),
    .redirect_addr(redirect_addr), .spec_level(spec_level), .stall(stall)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic bit exp_stall();
    return (ckpt_req && lvl == DEP) || fault || nonckpt_wr || (sc == SBD);
  endfunction

  task automatic model_step();
    bit mis, hit, push, com, acc;
    int ntag, z;
    mis  = res_valid && res_mispred && lvl != 0;
    hit  = res_valid && !res_mispred && lvl != 0;
    push = ckpt_req && lvl < DEP && !mis;
    com  = sc > 0 && stg[0] == 0 && cm_ready;
    acc  = st_valid && sc < SBD && !mis;
    ntag = lvl - (hit ? 1 : 0);
    m_rv = mis;
    if (mis) begin
      m_rregs = mr[0]; m_rflags = mf[0]; m_renv = me[0]; m_redir = res_target;
    end
    if (com) begin
      for (int i = 0; i < SBD - 1; i++) begin
        sa[i] = sa[i+1]; sd[i] = sd[i+1]; stg[i] = stg[i+1];
      end
      sc--;
    end
    if (mis) begin
      z = 0;
      for (int i = 0; i < sc; i++) if (stg[i] == 0) z++;
      sc = z;
    end
    if (hit) for (int i = 0; i < sc; i++) if (stg[i] > 0) stg[i]--;
    if (acc) begin
      sa[sc] = st_addr; sd[sc] = st_data; stg[sc] = ntag; sc++;
    end
    if (mis) lvl = 0;
    else begin
      if (hit) begin
        for (int i = 0; i < DEP - 1; i++) begin
          mr[i] = mr[i+1]; mf[i] = mf[i+1]; me[i] = me[i+1];
        end
        lvl--;
      end
      if (push) begin
        mr[lvl] = ckpt_regs; mf[lvl] = ckpt_flags; me[lvl] = ckpt_env; lvl++;
      end
    end
  endtask

  task automatic check_regs();
    chk("R2/R4 spec_level", 64'(spec_level), 64'(lvl));
    chk("R5 restore_valid", 64'(restore_valid), 64'(m_rv));
    if (m_rv) begin
      chk("R5 restore_regs", restore_regs, m_rregs);
      chk("R5 restore_flags", 64'(restore_flags), 64'(m_rflags));
      chk("R5 restore_env", 64'(restore_env), 64'(m_renv));
      chk("R5 redirect_addr", 64'(redirect_addr), 64'(m_redir));
    end
    chk("R7 cm_valid", 64'(cm_valid), 64'(sc > 0 && stg[0] == 0));
    if (sc > 0 && stg[0] == 0) begin
      chk("R7 cm_addr", 64'(cm_addr), 64'(sa[0]));
      chk("R7 cm_data", 64'(cm_data), 64'(sd[0]));
    end
  endtask

  task automatic step(input bit req, input bit rv, input bit mp, input bit flt,
                      input bit nck, input bit sv, input bit cr);
    ckpt_req = req; res_valid = rv; res_mispred = mp; fault = flt;
    nonckpt_wr = nck; st_valid = sv; cm_ready = cr;
    ckpt_regs = {$urandom, $urandom}; ckpt_flags = 8'($urandom);
    ckpt_env = 8'($urandom); res_target = 16'($urandom);
    st_addr = 16'($urandom); st_data = 16'($urandom);
    #1;
    chk("R9 stall", 64'(stall), 64'(exp_stall()));
    chk("R10 st_ready", 64'(st_ready), 64'(sc < SBD));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_regs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] p2_regs;
    logic [15:0] a_addr;
    int drained;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 level", 64'(spec_level), 0);
    chk("R1 restore_valid", 64'(restore_valid), 0);
    chk("R1 cm_valid", 64'(cm_valid), 0);
    chk("R1 st_ready", 64'(st_ready), 1);
    chk("R1 stall", 64'(stall), 0);
    @(negedge clk);

    // store A at level 0, then four pushes; store C rides push 2
    step(0,0,0,0,0,1,0); a_addr = sa[0];
    step(1,0,0,0,0,0,0);
    step(1,0,0,0,0,1,0); p2_regs = mr[1];
    step(1,0,0,0,0,0,0);
    step(1,0,0,0,0,0,0);
    chk("R2 level four", 64'(spec_level), 4);
    ckpt_req = 1; #1;
    chk("R3 stall at top", 64'(stall), 1);
    step(1,0,0,0,0,0,0);
    chk("R3 level held", 64'(spec_level), 4);
    step(0,1,0,0,0,0,0);
    chk("R4 level drop", 64'(spec_level), 3);
    chk("R4 no restore", 64'(restore_valid), 0);
    step(0,0,0,0,0,1,0);  // store D, tag 3
    step(1,1,1,0,0,1,0);  // mispredict, request and store dropped
    chk("R5 restore strobe", 64'(restore_valid), 1);
    chk("R5 oldest regs", restore_regs, p2_regs);
    chk("R5 level cleared", 64'(spec_level), 0);
    chk("R8 head kept", 64'(cm_addr), 64'(a_addr));
    step(0,0,0,0,0,0,1);
    step(0,0,0,0,0,0,1);
    chk("R8 tagged store flushed", 64'(cm_valid), 0);
    step(1,0,0,0,0,0,0);
    step(0,0,0,0,0,1,1);
    chk("R7 tagged store held", 64'(cm_valid), 0);
    step(0,1,0,0,0,0,0);
    chk("R7 store released", 64'(cm_valid), 1);
    step(0,0,0,0,0,0,1);
    step(0,1,1,0,0,0,0);
    chk("R6 idle resolve level", 64'(spec_level), 0);
    chk("R6 idle resolve restore", 64'(restore_valid), 0);
    fault = 1; #1; chk("R9 fault stall", 64'(stall), 1);
    step(0,0,0,1,0,0,0);
    nonckpt_wr = 1; #1; chk("R9 nonckpt stall", 64'(stall), 1);
    step(0,0,0,0,1,0,0);
    for (int i = 0; i < 5; i++) step(0,0,0,0,0,1,0);
    chk("R10 full ready", 64'(st_ready), 0);
    chk("R10 full stall", 64'(stall), 1);
    drained = 0;
    for (int i = 0; i < 6; i++) begin
      if (cm_valid) drained++;
      step(0,0,0,0,0,0,1);
    end
    chk("R10 extra store ignored", 64'(drained), 4);

    for (int n = 0; n < 3000; n++) begin
      bit rv;
      rv = ($urandom % 10) < 3;
      step(($urandom % 10) < 4, rv, rv && (($urandom % 4) == 0),
           ($urandom % 20) == 0, ($urandom % 20) == 0,
           ($urandom % 10) < 4, ($urandom % 10) < 6);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule